// File: doc/BRIEF.md
# Programmable Chip-Select Area Decoder

This block maps each external bus access to one of six chip-select areas and drives the matching active-low select line together with the active-low read or write strobes. Areas 1 to 5 are programmable windows. Each window is set by a 16-bit base tag and a 16-bit mask that act on address bits 31:16, so a window is aligned to 64 KB or to a larger power-of-two multiple of 64 KB, and it can sit anywhere in the 4 GB space. Area 0 has no registers. It claims every address that no programmable window matches.

An access is offered on `acc_valid` with its address, its direction and its byte-lane enables. The select and strobe outputs are registered: they reflect the access one clock later and return high on the following clock unless another access is offered. All pins are plain control pins. There is no handshake and no back-pressure, and the block accepts one access per clock. A one-word configuration port writes either the base or the mask of one area per clock.

Top module: `csel_area_decoder`

## Requirements
- R1: After reset, area n (n = 1..5) has base tag n and mask 0. Addresses 0x0001_0000 to 0x0005_FFFF therefore fall into areas 1 to 5 in 64 KB steps, and every other address falls into area 0.
- R2: Area n matches when `((addr[31:16] XOR base_n) AND NOT mask_n) == 0`. A mask bit of 1 makes that address bit "don't care". Address bits 15:0 never affect the decode.
- R3: An access that no programmable area matches drives `cs_n[0]` low.
- R4: When several areas match, the lowest-numbered one wins. Every access drives exactly one `cs_n` bit low.
- R5: In a clock with no access, the registered outputs `cs_n`, `rd_n` and `wr_n` are all high on the next clock.
- R6: A read (`acc_write`=0) drives `rd_n` low and keeps both `wr_n` bits high. A write drives `wr_n[i]` low exactly for each lane i with `acc_be[i]`=1 and keeps `rd_n` high.
- R7: A configuration write with `cfg_area` in 1..5 loads `cfg_data` into the base (`cfg_field`=0) or the mask (`cfg_field`=1) of that area. An access in the same clock still uses the old value, and accesses from the next clock onward use the new one. Writes with `cfg_area` equal to 0, 6 or 7 change nothing.
- R8: Outputs for an access offered in clock k appear after the clock edge that ends clock k and hold for one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_area | input | 3 | Area number targeted by the write |
| cfg_field | input | 1 | 0 = base tag, 1 = mask |
| cfg_data | input | 16 | Value to write |
| acc_valid | input | 1 | An external access is offered this clock |
| acc_addr | input | 32 | Access byte address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_be | input | 2 | Byte-lane enables for writes |
| cs_n | output | 6 | Active-low chip selects, bit n = area n |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 2 | Active-low per-lane write strobes |

## Verification
The bench builds the decoder with its default parameters: a 32-bit address, a 64 KB granule, five programmable areas and two write lanes. With these values the reset layout can be checked at the exact edges 0x0001_0000 and 0x0005_FFFF. Windows of 512 KB and 1 MB can be built by masking low tag bits, and a fully masked area 5 turns into a catch-all behind areas 1 to 4, which exercises the priority rule. Every lane-enable pattern of the two write strobes is reachable, and so are writes to the unused area codes 0, 6 and 7.

// File: rtl/csd_pkg.sv
package csd_pkg;

  typedef enum logic {
    FLD_BASE = 1'b0,
    FLD_MASK = 1'b1
  } csd_field_e;

  // Window hit test on the upper address tag; mask bit 1 = don't care
  function automatic logic tag_hit(input logic [15:0] tag,
                                   input logic [15:0] base,
                                   input logic [15:0] mask);
    return ((tag ^ base) & ~mask) == '0;
  endfunction

endpackage

// File: rtl/csd_regfile.sv
module csd_regfile #(
  parameter int N_AREAS = 5,
  parameter int TAG_W   = 16,
  parameter int IDX_W   = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [IDX_W-1:0]                wr_area,
  input  logic                            wr_field,
  input  logic [TAG_W-1:0]                wr_data,
  output logic [N_AREAS-1:0][TAG_W-1:0]   base_o,
  output logic [N_AREAS-1:0][TAG_W-1:0]   mask_o
);
  import csd_pkg::*;

  logic [N_AREAS-1:0][TAG_W-1:0] base_q, mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < N_AREAS; n++) begin
        base_q[n] <= TAG_W'(n + 1);
        mask_q[n] <= '0;
      end
    end else if (wr_en) begin
      for (int n = 0; n < N_AREAS; n++) begin
        if (wr_area == IDX_W'(n + 1)) begin
          if (wr_field == FLD_MASK) mask_q[n] <= wr_data;
          else                      base_q[n] <= wr_data;
        end
      end
    end
  end

  assign base_o = base_q;
  assign mask_o = mask_q;

  // R7: writes aimed at an unused area code leave all registers untouched
  assert_ignore_unused_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_area == '0 || int'(wr_area) > N_AREAS))
      |=> ($stable(base_q) && $stable(mask_q)));

endmodule

// File: rtl/csd_match.sv
module csd_match #(
  parameter int N_AREAS = 5,
  parameter int TAG_W   = 16
) (
  input  logic [TAG_W-1:0]               tag,
  input  logic [N_AREAS-1:0][TAG_W-1:0]  base_i,
  input  logic [N_AREAS-1:0][TAG_W-1:0]  mask_i,
  output logic [N_AREAS-1:0]             hit_o
);
  import csd_pkg::*;

  for (genvar n = 0; n < N_AREAS; n++) begin : g_win
    if (TAG_W == 16) begin : g_pkg
      assign hit_o[n] = tag_hit(tag, base_i[n], mask_i[n]);
    end else begin : g_gen
      assign hit_o[n] = ((tag ^ base_i[n]) & ~mask_i[n]) == '0;
    end
  end

endmodule

// File: rtl/csd_prio.sv
module csd_prio #(
  parameter int N_AREAS = 5
) (
  input  logic [N_AREAS-1:0] hit_i,
  output logic [N_AREAS:0]   grant_o
);
  logic found;

  // bit 0 of grant is the fallback area; bit n+1 is programmable area n+1
  always_comb begin
    grant_o = '0;
    found   = 1'b0;
    for (int n = 0; n < N_AREAS; n++) begin
      if (hit_i[n] && !found) begin
        grant_o[n + 1] = 1'b1;
        found          = 1'b1;
      end
    end
    if (!found) grant_o[0] = 1'b1;
  end

endmodule

// File: rtl/csel_area_decoder.sv
module csel_area_decoder #(
  parameter  int ADDR_W    = 32,
  parameter  int GRAN_BITS = 16,
  parameter  int N_AREAS   = 5,
  parameter  int LANES     = 2,
  localparam int TAG_W     = ADDR_W - GRAN_BITS,
  localparam int IDX_W     = $clog2(N_AREAS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_area,
  input  logic              cfg_field,
  input  logic [TAG_W-1:0]  cfg_data,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic [LANES-1:0]  acc_be,
  output logic [N_AREAS:0]  cs_n,
  output logic              rd_n,
  output logic [LANES-1:0]  wr_n
);

  logic [N_AREAS-1:0][TAG_W-1:0] base_w, mask_w;
  logic [N_AREAS-1:0]            hit_w;
  logic [N_AREAS:0]              grant_w;
  logic [N_AREAS:0]              cs_n_q;
  logic                          rd_n_q;
  logic [LANES-1:0]              wr_n_q;

  csd_regfile #(.N_AREAS(N_AREAS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_area  (cfg_area),
    .wr_field (cfg_field),
    .wr_data  (cfg_data),
    .base_o   (base_w),
    .mask_o   (mask_w)
  );

  csd_match #(.N_AREAS(N_AREAS), .TAG_W(TAG_W)) u_match (
    .tag    (acc_addr[ADDR_W-1:GRAN_BITS]),
    .base_i (base_w),
    .mask_i (mask_w),
    .hit_o  (hit_w)
  );

  csd_prio #(.N_AREAS(N_AREAS)) u_prio (
    .hit_i   (hit_w),
    .grant_o (grant_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_q <= '1;
      rd_n_q <= 1'b1;
      wr_n_q <= '1;
    end else if (acc_valid) begin
      cs_n_q <= ~grant_w;
      rd_n_q <= acc_write;
      wr_n_q <= acc_write ? ~acc_be : '1;
    end else begin
      cs_n_q <= '1;
      rd_n_q <= 1'b1;
      wr_n_q <= '1;
    end
  end

  assign cs_n = cs_n_q;
  assign rd_n = rd_n_q;
  assign wr_n = wr_n_q;

  // R4: one select per access
  assert_one_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> ($countones(~cs_n) == 1));

  // R3: unmatched access falls back to area 0
  assert_fallback_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && hit_w == '0) |=> !cs_n[0]);

  // R5: quiet outputs after an idle clock
  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (&cs_n && rd_n && &wr_n));

  // R6: read and write strobes never overlap
  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> &wr_n);

endmodule

// File: tb/csel_area_decoder_tb.sv
module csel_area_decoder_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_area = '0;
  logic        cfg_field = 1'b0;
  logic [15:0] cfg_data = '0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic [1:0]  acc_be = '0;
  logic [5:0]  cs_n;
  logic        rd_n;
  logic [1:0]  wr_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [8:0] v;
    string      tag;
  } exp_t;
  exp_t sb[$];

  logic [15:0] sh_base [1:5];
  logic [15:0] sh_mask [1:5];

  always #10 clk = ~clk;

  csel_area_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_area(cfg_area),
    .cfg_field(cfg_field), .cfg_data(cfg_data), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_write(acc_write), .acc_be(acc_be),
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  function automatic logic [8:0] model(input logic v, input logic [31:0] a,
                                       input logic w, input logic [1:0] be);
    int sel = 0;
    logic [5:0] c;
    if (!v) return 9'h1FF;
    for (int n = 5; n >= 1; n--)
      if (((a[31:16] ^ sh_base[n]) & ~sh_mask[n]) == 16'h0) sel = n;
    c = ~(6'b1 << sel);
    return {c, w, (w ? ~be : 2'b11)};
  endfunction

  task automatic check(input logic [8:0] act, input logic [8:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got cs_n/rd_n/wr_n=%b expected %b", tag, act, exp);
    end
  endtask

  // driver: one clock of stimulus, expected result pushed to the scoreboard
  task automatic step(input logic v, input logic [31:0] a, input logic w,
                      input logic [1:0] be, input logic we, input logic [2:0] ar,
                      input logic fld, input logic [15:0] d, input string tag);
    exp_t e;
    @(negedge clk);
    acc_valid = v; acc_addr = a; acc_write = w; acc_be = be;
    cfg_we = we; cfg_area = ar; cfg_field = fld; cfg_data = d;
    e.v = model(v, a, w, be);
    e.tag = tag;
    sb.push_back(e);
    if (we && ar >= 3'd1 && ar <= 3'd5) begin
      if (fld) sh_mask[ar] = d; else sh_base[ar] = d;
    end
  endtask

  task automatic rd(input logic [31:0] a, input string tag);
    step(1'b1, a, 1'b0, 2'b00, 1'b0, 3'd0, 1'b0, 16'h0, tag);
  endtask

  task automatic cfg(input logic [2:0] ar, input logic fld, input logic [15:0] d,
                     input string tag);
    step(1'b0, 32'h0, 1'b0, 2'b00, 1'b1, ar, fld, d, tag);
  endtask

  // monitor: compares after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check({cs_n, rd_n, wr_n}, e.v, e.tag);
      end
    end
  end

  initial begin
    #(200000 * 20);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int n = 1; n <= 5; n++) begin
      sh_base[n] = 16'(n);
      sh_mask[n] = 16'h0;
    end
    repeat (3) @(posedge clk);
    #2;
    check({cs_n, rd_n, wr_n}, 9'h1FF, "R5 reset outputs high");
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset layout, R3 fallback, R8 one-cycle latency via scoreboard
    rd(32'h0000_FFFF, "R1 below window");
    rd(32'h0001_0000, "R1 area1 low edge");
    rd(32'h0001_FFFF, "R1 area1 high edge");
    rd(32'h0002_1234, "R1 area2");
    rd(32'h0003_8000, "R1 area3");
    rd(32'h0004_0001, "R1 area4");
    rd(32'h0005_FFFF, "R1 area5 top");
    rd(32'h0006_0000, "R3 above window");
    rd(32'hFFFF_0000, "R3 top of space");
    step(1'b0, 32'h0002_0000, 1'b0, 2'b00, 1'b0, 3'd0, 1'b0, 16'h0, "R5 idle");
    step(1'b0, 32'h0001_0000, 1'b1, 2'b11, 1'b0, 3'd0, 1'b0, 16'h0, "R5 idle write");

    // R6 write lanes
    step(1'b1, 32'h0003_0010, 1'b1, 2'b01, 1'b0, 3'd0, 1'b0, 16'h0, "R6 lane0");
    step(1'b1, 32'h0003_0010, 1'b1, 2'b10, 1'b0, 3'd0, 1'b0, 16'h0, "R6 lane1");
    step(1'b1, 32'h0009_0000, 1'b1, 2'b11, 1'b0, 3'd0, 1'b0, 16'h0, "R6 both lanes");
    step(1'b1, 32'h0004_0000, 1'b1, 2'b00, 1'b0, 3'd0, 1'b0, 16'h0, "R6 no lanes");

    // R7 same-cycle write uses old value, next access uses new
    step(1'b1, 32'h0001_0000, 1'b0, 2'b00, 1'b1, 3'd1, 1'b0, 16'h0100, "R7 old value");
    rd(32'h0001_0000, "R7 new base gone");
    rd(32'h0100_ABCD, "R7 new base hit");

    // R7 unused codes ignored, observed through decode
    cfg(3'd0, 1'b0, 16'h0002, "R7 area0 write idle");
    cfg(3'd6, 1'b1, 16'hFFFF, "R7 area6 write idle");
    cfg(3'd7, 1'b0, 16'h0009, "R7 area7 write idle");
    rd(32'h0002_0000, "R7 area2 unchanged");
    rd(32'h0009_0000, "R7 no stray window");
    rd(32'h0006_0000, "R7 still area0");

    // R2 512 KB window for area1 at 0, overlapping areas 2..5 (R4)
    cfg(3'd1, 1'b0, 16'h0000, "R2 cfg base1");
    cfg(3'd1, 1'b1, 16'h0007, "R2 cfg mask1");
    rd(32'h0007_FFFF, "R2 512K top");
    rd(32'h0003_0000, "R4 area1 beats area3");
    rd(32'h0008_0000, "R2 512K outside");

    // R2 1 MB windows for areas 2..5
    for (int n = 2; n <= 5; n++) begin
      cfg(3'(n), 1'b0, 16'(16 * (n - 1)), "R2 cfg base 1M");
      cfg(3'(n), 1'b1, 16'h000F, "R2 cfg mask 1M");
    end
    rd(32'h0010_0000, "R2 area2 1M low");
    rd(32'h001F_FFFF, "R2 area2 1M high");
    rd(32'h0025_5555, "R2 area3 1M");
    rd(32'h003C_0000, "R2 area4 1M");
    rd(32'h004F_FFFF, "R2 area5 1M top");
    rd(32'h0050_0000, "R3 beyond 1M windows");

    // R4 overlap: area3 narrow inside area2 wide
    cfg(3'd2, 1'b0, 16'h0100, "R4 cfg base2");
    cfg(3'd2, 1'b1, 16'h00FF, "R4 cfg mask2");
    cfg(3'd3, 1'b0, 16'h0142, "R4 cfg base3");
    cfg(3'd3, 1'b1, 16'h0000, "R4 cfg mask3");
    rd(32'h0142_0000, "R4 area2 beats area3");

    // R4 fully masked area5 becomes catch-all behind 1..4
    cfg(3'd5, 1'b1, 16'hFFFF, "R4 cfg mask5");
    rd(32'hDEAD_BEEF, "R4 area5 catch-all");
    rd(32'h0000_1000, "R4 area1 beats area5");
    step(1'b1, 32'h0123_4567, 1'b1, 2'b10, 1'b0, 3'd0, 1'b0, 16'h0, "R6 write in area2");
    step(1'b0, 32'h0, 1'b0, 2'b00, 1'b0, 3'd0, 1'b0, 16'h0, "R5 final idle");

    repeat (3) @(posedge clk);
    #5;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    done = 1'b1;
    $finish;
  end

endmodule